// File: doc/BRIEF.md
# Transmit Checksum Offload Engine

This block finishes a transmit frame before it goes to the MAC. Software places the frame in a local byte buffer through a simple write port. When offload is requested, an 8-byte control block sits in front of the Ethernet frame in that buffer. The control block gives the layer-3 and layer-4 header positions as offsets, so the engine does not parse any headers to find them. It also gives a set of request flags. With these, the engine fills in the IPv4 header checksum and the TCP or UDP checksum. A UDP frame that does not ask for a checksum gets its checksum field cleared. The engine then streams the frame out one byte per cycle, without the control block.

A start pulse hands over the buffer, together with the frame length and a flag that says whether a control block is present. A frame with a control block goes through two passes. The first pass reads the whole buffer once and collects the decoded fields and two ones'-complement sums in parallel. The second pass reads the buffer again and emits the bytes, replacing the checksum fields as they pass. A frame without a control block is emitted unchanged, with no first pass. The buffer itself is never modified. The engine assumes sane offsets: the layer-4 header lies after the 20 address bytes of the IPv4 header, and a frame with a control block is longer than 8 bytes.

Top module: `cko_tx_offload`

## Requirements
- R1: After reset, `out_valid`, `out_last` and `busy` are low.
- R2: Control block layout. The flags are in buffer byte 0:
  - bit0: IPv4 present
  - bit1: TCP/UDP present
  - bit2: UDP (clear means TCP)
  - bit3: compute the IPv4 checksum
  - bit4: compute the TCP/UDP checksum

  Byte 3 is the layer-3 offset from the Ethernet frame start, which is buffer byte 8. Byte 2 is the layer-4 offset from the layer-3 start. Both offsets move the patched positions accordingly, and the IPv4 header length comes from the low nibble of the first layer-3 byte, in 32-bit words.
- R3: With `has_fcb` high, the output is buffer bytes 8 to `frame_len`-1 in order, one per cycle. `out_last` is high on the final byte only.
- R4: With `has_fcb` low, the output is buffer bytes 0 to `frame_len`-1 unchanged.
- R5: When bit0 and bit3 are set, layer-3 bytes 10 and 11 carry the complemented ones'-complement sum of the IPv4 header, high byte first. The checksum field counts as zero in that sum.
- R6: When bit0, bit1, bit2 and bit4 are set, layer-4 bytes 6 and 7 carry the UDP checksum, high byte first. The sum covers:
  - the source and destination addresses (layer-3 bytes 12 to 19)
  - the protocol byte (layer-3 byte 9)
  - the layer-4 length, which runs to the end of the buffer
  - the layer-4 bytes, with the checksum field taken as zero and an odd last byte padded low

  A result of 0x0000 is sent as 0xFFFF.
- R7: When bit0, bit1 and bit2 are set and bit4 is clear, layer-4 bytes 6 and 7 are sent as zero.
- R8: When bit0 and bit1 are set and bit2 is clear, layer-4 bytes 16 and 17 carry the TCP checksum, formed as in R6 without the 0xFFFF substitution, if bit4 is set. If bit4 is clear, they pass unchanged.
- R9: With bit0 clear, no byte is changed, whatever the other flags say.
- R10: A start while `busy` is high is ignored, and so is a start with `frame_len` of zero. Consecutive frames are separated by at least one idle output cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Buffer byte write enable |
| wr_addr | input | AW | Buffer byte address |
| wr_data | input | 8 | Buffer byte data |
| start | input | 1 | Begin processing the buffered frame |
| frame_len | input | AW | Number of valid buffer bytes, control block included |
| has_fcb | input | 1 | The buffer starts with an 8-byte control block |
| busy | output | 1 | A frame is being processed or emitted |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the frame |

## Verification
The hardest case to reach from the ports is a computed UDP checksum of 0x0000, which must go out as 0xFFFF. Random payloads almost never produce it. The bench builds a UDP frame and first computes the sum with one aligned payload word set to zero. It then writes the complement of that sum into the word, so the full sum becomes 0xFFFF. Non-default header positions (an 18-byte layer-3 offset with IPv4 options), an odd layer-4 length, and a second start pulse issued mid-frame are driven as separate frames.

// File: rtl/cko_pkg.sv
package cko_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SCAN, ST_DRAIN, ST_FIN, ST_LATCH, ST_EMIT
  } cko_state_e;

  // flag bit positions in control block byte 0
  localparam int FL_IP  = 0;
  localparam int FL_L4  = 1;
  localparam int FL_UDP = 2;
  localparam int FL_CIP = 3;
  localparam int FL_CL4 = 4;

  // control block byte positions
  localparam int CB_FLAGS  = 0;
  localparam int CB_L4OFF  = 2;
  localparam int CB_L3OFF  = 3;
  localparam int CB_BYTES  = 8;

  // checksum field positions inside headers
  localparam int IP_CK_OFS  = 10;
  localparam int IP_PROTO   = 9;
  localparam int IP_SRC     = 12;
  localparam int IP_ADDR_END = 20;
  localparam int UDP_CK_OFS = 6;
  localparam int TCP_CK_OFS = 16;
endpackage

// File: rtl/cko_frame_ram.sv
module cko_frame_ram #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/cko_ones_acc.sv
module cko_ones_acc #(
  parameter int ACCW = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        en,
  input  logic [16:0] word,
  output logic [15:0] sum
);
  logic [ACCW-1:0] acc;
  logic [16:0]     fold1;

  always_ff @(posedge clk) begin
    if (rst || clr) acc <= '0;
    else if (en)    acc <= acc + ACCW'(word);
  end

  // end-around carry folding of the wide accumulator
  always_comb begin
    fold1 = 17'(acc[15:0]) + 17'(acc[ACCW-1:16]);
    sum   = fold1[15:0] + 16'(fold1[16]);
  end

  // headroom must never be consumed by a frame that fits in the buffer
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    !acc[ACCW-1]);
endmodule

// File: rtl/cko_tx_offload.sv
module cko_tx_offload
  import cko_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          start,
  input  logic [AW-1:0] frame_len,
  input  logic          has_fcb,
  output logic          busy,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_last
);
  localparam int PW   = AW + 1;
  localparam int ACCW = 32;

  cko_state_e    state;
  logic [AW-1:0] ptr, len_q, q_addr;
  logic          fcb_q, q_scan, q_emit;
  logic [7:0]    flags, l3off, l4off, proto;
  logic [PW-1:0] ihl4;
  logic [15:0]   ip_ck, l4_ck;
  logic [7:0]    rd_data;
  logic          rd_en, last_issue, accept;

  assign rd_en      = (state == ST_SCAN) || (state == ST_EMIT);
  assign last_issue = (ptr == len_q - AW'(1));
  assign busy       = (state != ST_IDLE) || q_scan || q_emit;
  assign accept     = start && !busy && (frame_len != '0);

  cko_frame_ram #(.AW(AW)) u_ram (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .re(rd_en), .raddr(ptr), .rdata(rd_data)
  );

  // header geometry from the decoded control block
  logic [PW-1:0] l3s, l4s, ip_end, aw, rel3, rel4, ck_pos, l4len;
  logic          is_udp;
  always_comb begin
    is_udp = flags[FL_UDP];
    l3s    = PW'(CB_BYTES) + PW'(l3off);
    l4s    = l3s + PW'(l4off);
    ip_end = l3s + ihl4;
    aw     = PW'(q_addr);
    rel3   = aw - l3s;
    rel4   = aw - l4s;
    ck_pos = l4s + (is_udp ? PW'(UDP_CK_OFS) : PW'(TCP_CK_OFS));
    l4len  = PW'(len_q) - l4s;
  end

  // per-byte contribution during the scan pass
  logic        in_ip, in_ph, in_l4, ip_en, l4_en;
  logic [16:0] ip_word, l4_word, hi_w, lo_w;
  always_comb begin
    hi_w  = {1'b0, rd_data, 8'h00};
    lo_w  = {9'b0, rd_data};
    in_ip = q_scan && (aw >= l3s) && ((aw == l3s) || (aw < ip_end))
            && (rel3 != PW'(IP_CK_OFS)) && (rel3 != PW'(IP_CK_OFS + 1));
    in_ph = q_scan && (aw >= l3s) && (rel3 >= PW'(IP_SRC))
            && (rel3 < PW'(IP_ADDR_END));
    in_l4 = q_scan && (aw >= l4s) && (aw != ck_pos) && (aw != ck_pos + PW'(1));
    ip_word = rel3[0] ? lo_w : hi_w;
    ip_en   = in_ip;
    if (state == ST_FIN) begin
      l4_word = 17'(proto) + 17'(l4len);
      l4_en   = 1'b1;
    end else begin
      l4_word = in_ph ? (rel3[0] ? lo_w : hi_w) : (rel4[0] ? lo_w : hi_w);
      l4_en   = in_ph || in_l4;
    end
  end

  logic [15:0] ip_sum, l4_sum;

  cko_ones_acc #(.ACCW(ACCW)) u_ip_acc (
    .clk(clk), .rst(rst), .clr(accept), .en(ip_en), .word(ip_word), .sum(ip_sum)
  );
  cko_ones_acc #(.ACCW(ACCW)) u_l4_acc (
    .clk(clk), .rst(rst), .clr(accept), .en(l4_en), .word(l4_word), .sum(l4_sum)
  );

  // sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      ptr   <= '0;
      len_q <= '0;
      fcb_q <= 1'b0;
      ip_ck <= '0;
      l4_ck <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          len_q <= frame_len;
          fcb_q <= has_fcb;
          ptr   <= '0;
          state <= has_fcb ? ST_SCAN : ST_EMIT;
        end
        ST_SCAN: begin
          ptr <= ptr + AW'(1);
          if (last_issue) state <= ST_DRAIN;
        end
        ST_DRAIN: state <= ST_FIN;
        ST_FIN:   state <= ST_LATCH;
        ST_LATCH: begin
          ip_ck <= ~ip_sum;
          l4_ck <= (is_udp && (l4_sum == 16'hFFFF)) ? 16'hFFFF : ~l4_sum;
          ptr   <= AW'(CB_BYTES);
          state <= (len_q > AW'(CB_BYTES)) ? ST_EMIT : ST_IDLE;
        end
        ST_EMIT: begin
          ptr <= ptr + AW'(1);
          if (last_issue) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // read pipeline tags and control block capture
  always_ff @(posedge clk) begin
    if (rst) begin
      q_scan <= 1'b0;
      q_emit <= 1'b0;
      q_addr <= '0;
      flags  <= '0;
      l3off  <= '0;
      l4off  <= '0;
      proto  <= '0;
      ihl4   <= '0;
    end else begin
      q_scan <= (state == ST_SCAN);
      q_emit <= (state == ST_EMIT);
      q_addr <= ptr;
      if (q_scan) begin
        if (q_addr == AW'(CB_FLAGS)) flags <= rd_data;
        if (q_addr == AW'(CB_L4OFF)) l4off <= rd_data;
        if (q_addr == AW'(CB_L3OFF)) l3off <= rd_data;
        if ((q_addr >= AW'(CB_BYTES)) && (aw == l3s)) ihl4 <= PW'({rd_data[3:0], 2'b00});
        if ((q_addr >= AW'(CB_BYTES)) && (aw == l3s + PW'(IP_PROTO))) proto <= rd_data;
      end
    end
  end

  // output patching
  logic       do_ip, l4_on;
  logic [7:0] patched;
  always_comb begin
    do_ip   = fcb_q && flags[FL_IP] && flags[FL_CIP];
    l4_on   = fcb_q && flags[FL_IP] && flags[FL_L4];
    patched = rd_data;
    if (do_ip && (aw == l3s + PW'(IP_CK_OFS)))          patched = ip_ck[15:8];
    else if (do_ip && (aw == l3s + PW'(IP_CK_OFS + 1))) patched = ip_ck[7:0];
    else if (l4_on && (aw == ck_pos)) begin
      if (flags[FL_CL4]) patched = l4_ck[15:8];
      else if (is_udp)   patched = 8'h00;
    end else if (l4_on && (aw == ck_pos + PW'(1))) begin
      if (flags[FL_CL4]) patched = l4_ck[7:0];
      else if (is_udp)   patched = 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= q_emit;
      out_last  <= q_emit && (q_addr == len_q - AW'(1));
      out_data  <= q_emit ? patched : 8'h00;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_last && !busy));
  assert_last_with_valid_R3: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);
  assert_no_output_in_scan_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SCAN) |-> !out_valid);
  assert_frame_gap_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_last) |=> !out_valid);
endmodule

// File: tb/test_cko_tx_offload.sv
module test_cko_tx_offload;
  localparam int AW = 10;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, start = 1'b0, has_fcb = 1'b0;
  logic [AW-1:0] wr_addr = '0, frame_len = '0;
  logic [7:0] wr_data = '0;
  logic busy, out_valid, out_last;
  logic [7:0] out_data;

  always #2 clk = ~clk;

  cko_tx_offload #(.AW(AW)) i_cko_tx_offload (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start(start), .frame_len(frame_len), .has_fcb(has_fcb),
    .busy(busy), .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic [7:0] fr [0:(1<<AW)-1];
  logic [7:0] exp_d[$];
  logic       exp_l[$];
  string      exp_r[$];

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  // compare on every clock
  always @(negedge clk) begin : mon
    logic [7:0] d;
    logic l;
    string r;
    cyc++;
    if (cyc == 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
    if (!rst && out_valid) begin
      if (exp_d.size() == 0) check(1'b0, "R10 unexpected beat", out_data, 0);
      else begin
        d = exp_d.pop_front(); l = exp_l.pop_front(); r = exp_r.pop_front();
        check(out_data == d && out_last == l, r, {out_last, out_data}, {l, d});
      end
    end
  end

  function automatic logic [31:0] add_bytes(input logic [31:0] s, input int a,
                                            input int n, input int skip);
    for (int i = 0; i < n; i++)
      if (a + i != skip && a + i != skip + 1)
        s = s + ((i % 2 == 0) ? {16'h0, fr[a+i], 8'h00} : {24'h0, fr[a+i]});
    return s;
  endfunction

  function automatic logic [15:0] fold(input logic [31:0] s);
    while (s[31:16] != 0) s = {16'h0, s[15:0]} + {16'h0, s[31:16]};
    return s[15:0];
  endfunction

  function automatic logic [15:0] l4_raw(input int len);
    int l3s, l4s, ckp;
    logic [31:0] s;
    l3s = 8 + fr[3];
    l4s = l3s + fr[2];
    ckp = l4s + (fr[0][2] ? 6 : 16);
    s = add_bytes(32'h0, l3s + 12, 8, -10);
    s = s + fr[l3s+9] + (len - l4s);
    return fold(add_bytes(s, l4s, len - l4s, ckp));
  endfunction

  task automatic build(input int len, input int seed, input logic [7:0] fl,
                       input int l3off, input int ihl, input int l4off, input logic [7:0] pr);
    int l3s;
    for (int i = 0; i < len; i++) fr[i] = 8'(i * 37 + seed * 11 + 5);
    fr[0] = fl; fr[2] = 8'(l4off); fr[3] = 8'(l3off);
    l3s = 8 + l3off;
    fr[l3s] = 8'h40 | 8'(ihl);
    fr[l3s+9] = pr;
  endtask

  task automatic expect_frame(input bit fcb, input int len, input string base);
    int l3s, l4s, ckp, ihl;
    logic [7:0] fl, d;
    logic [15:0] ipc, l4c;
    string t;
    if (!fcb) begin
      for (int i = 0; i < len; i++) begin
        exp_d.push_back(fr[i]); exp_l.push_back(i == len - 1); exp_r.push_back(base);
      end
      return;
    end
    fl = fr[0]; l3s = 8 + fr[3]; l4s = l3s + fr[2]; ihl = fr[l3s] & 15;
    ckp = l4s + (fl[2] ? 6 : 16);
    ipc = ~fold(add_bytes(32'h0, l3s, ihl * 4, l3s + 10));
    l4c = ~l4_raw(len);
    if (fl[2] && l4c == 16'h0) l4c = 16'hFFFF;
    for (int i = 8; i < len; i++) begin
      d = fr[i]; t = base;
      if (fl[0] && fl[3] && i == l3s + 10)      begin d = ipc[15:8]; t = "R5 ip hi"; end
      else if (fl[0] && fl[3] && i == l3s + 11) begin d = ipc[7:0];  t = "R5 ip lo"; end
      else if (fl[0] && fl[1] && (i == ckp || i == ckp + 1)) begin
        if (fl[4]) begin d = (i == ckp) ? l4c[15:8] : l4c[7:0]; t = fl[2] ? "R6 udp csum" : "R8 tcp csum"; end
        else if (fl[2]) begin d = 8'h00; t = "R7 udp zeroed"; end
        else t = "R8 tcp untouched";
      end
      exp_d.push_back(d); exp_l.push_back(i == len - 1); exp_r.push_back(t);
    end
  endtask

  task automatic run(input bit fcb, input int len, input string base, input bit poke);
    for (int i = 0; i < len; i++) begin
      @(posedge clk); #1 wr_en = 1'b1; wr_addr = AW'(i); wr_data = fr[i];
    end
    @(posedge clk); #1 wr_en = 1'b0;
    expect_frame(fcb, len, base);
    start = 1'b1; has_fcb = fcb; frame_len = AW'(len);
    @(posedge clk); #1 start = 1'b0;
    if (poke) begin
      repeat (5) @(posedge clk);
      #1 start = 1'b1; has_fcb = ~fcb; frame_len = AW'(20);   // R10: ignored while busy
      @(posedge clk); #1 start = 1'b0;
    end
    do @(negedge clk); while (busy);
    repeat (2) @(negedge clk);
    check(exp_d.size() == 0, "R3 frame complete", exp_d.size(), 0);
    exp_d.delete(); exp_l.delete(); exp_r.delete();
  endtask

  initial begin
    logic [15:0] s;
    int l4s;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(!busy && !out_valid && !out_last, "R1 reset state", {busy, out_valid, out_last}, 0);

    // R10: zero length start ignored
    @(posedge clk); #1 start = 1'b1; frame_len = '0; has_fcb = 1'b0;
    @(posedge clk); #1 start = 1'b0;
    @(negedge clk);
    check(!busy, "R10 zero length ignored", busy, 0);

    build(80, 1, 8'h1F, 14, 5, 20, 8'd17);  run(1'b1, 80, "R3", 1'b0);   // UDP + IP
    build(75, 2, 8'h1B, 14, 5, 20, 8'd6);   run(1'b1, 75, "R3", 1'b0);   // TCP, odd
    build(70, 3, 8'h0F, 14, 5, 20, 8'd17);  run(1'b1, 70, "R7", 1'b0);   // UDP no csum
    build(90, 4, 8'h03, 14, 5, 20, 8'd6);   run(1'b1, 90, "R8", 1'b0);   // nothing computed
    build(64, 5, 8'h1F, 14, 5, 20, 8'd17);  run(1'b0, 64, "R4", 1'b0);   // pass-through
    build(72, 6, 8'h1E, 14, 5, 20, 8'd17);  run(1'b1, 72, "R9", 1'b0);   // no IP flag
    build(101, 7, 8'h1F, 18, 6, 24, 8'd17); run(1'b1, 101, "R2", 1'b0);  // offsets, options

    // R6 corner: force a UDP sum of 0xFFFF so the result 0 goes out as 0xFFFF
    build(84, 8, 8'h17, 14, 5, 20, 8'd17);
    l4s = 8 + 14 + 20;
    fr[l4s+8] = 8'h00; fr[l4s+9] = 8'h00;
    s = ~l4_raw(84);
    fr[l4s+8] = s[15:8]; fr[l4s+9] = s[7:0];
    run(1'b1, 84, "R6", 1'b0);

    build(66, 9, 8'h1F, 14, 5, 20, 8'd17);  run(1'b1, 66, "R10", 1'b1);  // start while busy

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule